// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block is a debug trigger that counts down on retired instructions and on taken exceptions. Only events that occur while the hart runs in a privilege mode whose enable bit is set are counted. When the count steps from one to zero, the trigger emits a one-cycle fire pulse that carries a 6-bit action code. The hart's debug logic decides what that code means.

Software programs the trigger through a single control register. The register holds a count field, three mode-enable bits and the action code, and it is written through a one-cycle write strobe. The register is always visible on a read-back bus.

A build-time option selects a single-step variant. In that variant the count is fixed at one. The trigger fires by clearing its three mode-enable bits instead of counting down. This disarms the trigger after one qualifying event.

Top module: `icnt_trigger`

## Requirements
- R1: The count field is bits 23:10 of the control register. The machine enable is bit 9, the supervisor enable is bit 7, the user enable is bit 6 and the action code is bits 5:0. Bit 8 always reads zero.
- R2: The privilege input uses 3 for machine, 1 for supervisor and 0 for user. Value 2 never matches any mode. A retire or exception pulse in a cycle whose mode has its enable set lowers a nonzero count by exactly one. The new value is visible on the read-back in the next cycle.
- R3: A retire pulse and an exception pulse in the same qualifying cycle lower the count by one, not two.
- R4: A retire or exception pulse in a mode whose enable bit is clear leaves the control register unchanged.
- R5: When a qualifying event steps the count from 1 to 0, `fire` is high for exactly the following cycle. During that cycle `fire_action` equals the action code. Whenever `fire` is low, `fire_action` is zero.
- R6: While the count is zero, qualifying events change nothing and never raise `fire`. This lasts until software writes a nonzero count.
- R7: A register write in the same cycle as a qualifying event takes priority. The written value is stored as is, no decrement happens and no fire follows.
- R8: With `STEP_MODE` = 1, the count field always reads 1. A qualifying event clears all three enable bits, keeps the action code and raises `fire` in the next cycle.
- R9: After reset the control register reads zero and `fire` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 24 | Control register write value |
| priv | input | 2 | Current privilege mode of the hart |
| retire | input | 1 | One instruction completed this cycle |
| exc_taken | input | 1 | An exception was taken this cycle |
| ctrl_q | output | 24 | Control register read-back |
| fire | output | 1 | Trigger fire pulse |
| fire_action | output | 6 | Action code presented with the fire pulse |

## Verification
Two pairs of functions can land in the same cycle. A software write can coincide with a qualifying event, and a retire can coincide with an exception. The bench provokes both. It writes a count of one while a qualifying retire is present, and it expects the written value to be stored with no fire in the next cycle. It also drives retire and exception together across every mode and every enable mask, and it expects a single-step decrement wherever the mode is enabled.

// File: rtl/icnt_pkg.sv
`timescale 1ns/1ps
package icnt_pkg;

  localparam int CNT_LSB  = 10;
  localparam int M_EN_BIT = 9;
  localparam int S_EN_BIT = 7;
  localparam int U_EN_BIT = 6;
  localparam int ACT_W    = 6;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;

  typedef struct packed {
    logic m;
    logic s;
    logic u;
  } mode_en_t;

  // True when the current privilege mode is one the trigger listens to.
  function automatic logic mode_match(priv_e p, mode_en_t en);
    case (p)
      PRV_M:   return en.m;
      PRV_S:   return en.s;
      PRV_U:   return en.u;
      default: return 1'b0;
    endcase
  endfunction

  // Count after one qualifying event, saturating at zero.
  function automatic logic [31:0] count_after(logic [31:0] c);
    return (c == 32'd0) ? 32'd0 : c - 32'd1;
  endfunction

endpackage

// File: rtl/icnt_event_qual.sv
`timescale 1ns/1ps
module icnt_event_qual
  import icnt_pkg::*;
(
  input  logic       retire,
  input  logic       exc_taken,
  input  logic [1:0] priv,
  input  mode_en_t   mode_en,
  output logic       hit
);

  logic any_evt;
  assign any_evt = retire | exc_taken;
  assign hit     = any_evt & mode_match(priv_e'(priv), mode_en);

endmodule

// File: rtl/icnt_ctrl_reg.sv
`timescale 1ns/1ps
module icnt_ctrl_reg
  import icnt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter bit STEP_MODE = 1'b0,
  localparam int REG_W    = CNT_LSB + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hit,
  output logic [CNT_W-1:0] cnt,
  output mode_en_t         mode_en,
  output logic [ACT_W-1:0] act,
  output logic             fire_set
);

  mode_en_t         en_q;
  logic [ACT_W-1:0] act_q;
  logic             en_clr;
  logic             take;

  // A write always wins over an event in the same cycle.
  assign take = hit & ~wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      act_q <= '0;
    end else if (wr_en) begin
      en_q.m <= wr_data[M_EN_BIT];
      en_q.s <= wr_data[S_EN_BIT];
      en_q.u <= wr_data[U_EN_BIT];
      act_q  <= wr_data[ACT_W-1:0];
    end else if (en_clr) begin
      en_q <= '0;
    end
  end

  generate
    if (STEP_MODE) begin : g_step
      logic unused_cnt_bits;
      assign unused_cnt_bits = ^wr_data[REG_W-1:CNT_LSB];
      assign cnt      = CNT_W'(1);
      assign fire_set = take;
      assign en_clr   = take;

      p_step_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_en) |=> (en_q == '0));
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             dec;
      assign dec      = take & (cnt_q != '0);
      assign fire_set = dec & (cnt_q == CNT_W'(1));
      assign en_clr   = 1'b0;
      assign cnt      = cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_en)  cnt_q <= wr_data[REG_W-1:CNT_LSB];
        else if (dec)    cnt_q <= cnt_q - 1'b1;
      end

      p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
      p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !wr_en) |=> $stable(cnt_q));
      p_zero_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !wr_en) |=> (cnt_q == '0));
      p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data[REG_W-1:CNT_LSB])));
    end
  endgenerate

  assign mode_en = en_q;
  assign act     = act_q;

  p_write_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (act_q == $past(wr_data[ACT_W-1:0]) &&
               en_q.m == $past(wr_data[M_EN_BIT])));

endmodule

// File: rtl/icnt_fire_gen.sv
`timescale 1ns/1ps
module icnt_fire_gen
  import icnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_set,
  input  logic [ACT_W-1:0] act,
  output logic             fire,
  output logic [ACT_W-1:0] fire_action
);

  logic             fire_q;
  logic [ACT_W-1:0] fact_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q <= 1'b0;
      fact_q <= '0;
    end else begin
      fire_q <= fire_set;
      fact_q <= fire_set ? act : '0;
    end
  end

  assign fire        = fire_q;
  assign fire_action = fact_q;

  p_fire_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  p_quiet_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (fire_action == '0));
  p_fire_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_set |=> fire);

endmodule

// File: rtl/icnt_trigger.sv
`timescale 1ns/1ps
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter bit STEP_MODE = 1'b0,
  localparam int REG_W    = CNT_LSB + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       priv,
  input  logic             retire,
  input  logic             exc_taken,
  output logic [REG_W-1:0] ctrl_q,
  output logic             fire,
  output logic [ACT_W-1:0] fire_action
);

  mode_en_t         mode_en;
  logic [CNT_W-1:0] cnt;
  logic [ACT_W-1:0] act;
  logic             hit;
  logic             fire_set;
  logic             unused_gap_bit;

  assign unused_gap_bit = wr_data[8];

  icnt_event_qual u_qual (
    .retire    (retire),
    .exc_taken (exc_taken),
    .priv      (priv),
    .mode_en   (mode_en),
    .hit       (hit)
  );

  icnt_ctrl_reg #(.CNT_W(CNT_W), .STEP_MODE(STEP_MODE)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .hit      (hit),
    .cnt      (cnt),
    .mode_en  (mode_en),
    .act      (act),
    .fire_set (fire_set)
  );

  icnt_fire_gen u_fire (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire_set    (fire_set),
    .act         (act),
    .fire        (fire),
    .fire_action (fire_action)
  );

  assign ctrl_q = {cnt, mode_en.m, 1'b0, mode_en.s, mode_en.u, act};

  p_gap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[8] == 1'b0);
  p_no_fire_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !fire);

endmodule

// File: tb/icnt_trigger_bench.sv
`timescale 1ns/1ps
module icnt_trigger_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_data = '0;
  logic [1:0]  priv = 2'd0;
  logic        retire = 1'b0;
  logic        exc_taken = 1'b0;
  logic [23:0] ctrl_q, ctrl_s;
  logic        fire, fire_s;
  logic [5:0]  fire_action, fire_action_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  icnt_trigger u_icnt_trigger (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .priv(priv),
    .retire(retire), .exc_taken(exc_taken), .ctrl_q(ctrl_q), .fire(fire),
    .fire_action(fire_action));

  icnt_trigger #(.STEP_MODE(1'b1)) u_icnt_trigger_step (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .priv(priv),
    .retire(retire), .exc_taken(exc_taken), .ctrl_q(ctrl_s), .fire(fire_s),
    .fire_action(fire_action_s));

  function automatic logic [23:0] pack(int cnt, int m, int s, int u, int a);
    return 24'((cnt << 10) | (m << 9) | (s << 7) | (u << 6) | (a & 63));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Apply inputs for one clock edge; return after the edge has settled.
  task automatic tick(logic w, logic [23:0] d, logic [1:0] p, logic r, logic e);
    wr_en = w; wr_data = d; priv = p; retire = r; exc_taken = e;
    @(negedge clk);
    wr_en = 1'b0; retire = 1'b0; exc_taken = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R9 reset ctrl", ctrl_q, 0);
    check("R9 reset fire", fire, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 field layout in both variants
    tick(1, 24'hFFFFFF, 0, 0, 0);
    check("R1 readback all ones", ctrl_q, 24'hFFFEFF);
    check("R8 step readback", ctrl_s, 24'h0006FF);

    // R2 R3 R4 sweep: every mask, every mode, every event kind
    for (int mask = 0; mask < 8; mask++) begin
      for (int p = 0; p < 4; p++) begin
        for (int k = 1; k < 4; k++) begin
          int m = (mask >> 2) & 1;
          int s = (mask >> 1) & 1;
          int u = mask & 1;
          int en_hit = (p == 3 && m == 1) || (p == 1 && s == 1) || (p == 0 && u == 1);
          tick(1, pack(5, m, s, u, mask + 8 * p), 2'(p), 0, 0);
          tick(0, 0, 2'(p), k[0], k[1]);
          if (en_hit != 0)
            check(k == 3 ? "R3 joint event" : "R2 decrement", ctrl_q,
                  pack(4, m, s, u, mask + 8 * p));
          else
            check("R4 disabled mode", ctrl_q, pack(5, m, s, u, mask + 8 * p));
        end
      end
    end

    // R5 count to zero and fire
    tick(1, pack(2, 1, 0, 0, 6'h2A), 3, 0, 0);
    tick(0, 0, 3, 1, 0);
    check("R5 no early fire", fire, 0);
    tick(0, 0, 3, 0, 1);
    check("R5 fire", fire, 1);
    check("R5 action", fire_action, 6'h2A);
    check("R5 count zero", ctrl_q, pack(0, 1, 0, 0, 6'h2A));
    tick(0, 0, 3, 0, 0);
    check("R5 one cycle", fire, 0);
    check("R5 action cleared", fire_action, 0);

    // R6 zero count ignores events
    tick(0, 0, 3, 1, 1);
    check("R6 no fire at zero", fire, 0);
    check("R6 count stays", ctrl_q, pack(0, 1, 0, 0, 6'h2A));

    // R7 write beats event in the same cycle
    tick(1, pack(1, 1, 1, 1, 6'h15), 3, 1, 0);
    check("R7 value stored", ctrl_q, pack(1, 1, 1, 1, 6'h15));
    tick(0, 0, 3, 0, 0);
    check("R7 no fire", fire, 0);
    tick(0, 0, 1, 1, 0);
    check("R7 later fire", fire, 1);
    check("R7 later action", fire_action, 6'h15);

    // R8 single step variant
    tick(1, pack(0, 0, 1, 0, 6'h07), 1, 0, 0);
    tick(0, 0, 1, 1, 0);
    check("R8 step fire", fire_s, 1);
    check("R8 step action", fire_action_s, 6'h07);
    check("R8 step disarmed", ctrl_s, 24'h000407);
    tick(0, 0, 1, 1, 0);
    check("R8 no second fire", fire_s, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule